// File: doc/BRIEF.md
# Watchdog Timer with Pre-Reset Interrupt

This block is a watchdog peripheral on a simple register bus. A 16-bit counter counts down once per millisecond. The millisecond step comes from dividing a slow 32.768 kHz tick by a fixed prescale value. When the counter steps from 1 to 0 the watchdog has expired. Software keeps it from expiring by kicking it: any write to the kick register reloads the counter from the load register.

Expiry has two possible outcomes, chosen by a mode bit in the control register. In reset mode the block emits a one-cycle reset request pulse to an external reset generator. In interrupt mode it sets a sticky status flag instead, with no reset request. The interrupt output is that flag gated by an enable bit. In both modes the counter reloads and keeps running after expiry. Software can use this to shorten the load value and arm a final countdown.

Three stall inputs can freeze the count: debug probe active, hibernation timer active and week timer active. Each one only takes effect while its own qualifier bit in the control register is set. Register reads are combinational from the address; writes take effect at the clock edge where `wr_en` is high.

Top module: `wdt_guard`

## Requirements
- R1: After reset, control reads 0, interrupt enable reads 0, status reads 0, load and count both read 0xFFFF, and `irq` and `rst_req` are low.
- R2: Register addresses are 0 control, 1 interrupt enable (bit 0), 2 status (flag at bit 0), 3 load, 4 kick and 5 count. Reads of the kick address return 0.
- R3: Control bit 0 is enable. A write that changes enable from 0 to 1 loads the counter from the load register and clears the prescaler. While enable is 0 the count holds its value and no expiry occurs.
- R4: While enabled, with `tick_32k` high every clock and the prescale value at 33, the count drops by one every 33 cycles. The first drop comes 33 cycles after the edge that starts or reloads the counter.
- R5: When control bit 1 is 0, expiry raises `rst_req` for exactly one cycle, in the cycle that is 33×L cycles after the start edge (L = the load value). The counter then reloads.
- R6: When control bit 1 is 1, expiry sets the status flag, never raises `rst_req`, and reloads the counter, which keeps running.
- R7: `irq` is high exactly when the status flag and interrupt-enable bit 0 are both set.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves the flag unchanged. If a new expiry falls in the same cycle as the clear, the flag stays set.
- R9: A write to the kick address reloads the counter and clears the prescaler, whatever data is written. A kick in the same cycle as an expiry step wins, and no expiry occurs in that cycle.
- R10: Writing 0 to the load register stores 1.
- R11: Control bits 2, 3 and 4 qualify `stall_dbg`, `stall_hib` and `stall_wk`. While a qualified stall input is high, both the count and the prescaler hold. A stall input whose bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle strobe at the slow tick rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| stall_dbg | input | 1 | Debug probe active |
| stall_hib | input | 1 | Hibernation timer active |
| stall_wk | input | 1 | Week timer active |
| irq | output | 1 | Pre-reset interrupt |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Two functions can fall in the same cycle: a kick and an expiry step. The bench provokes this by timing the kick write onto exactly the clock edge where the count would step from 1 to 0. A scoreboard then expects no reset pulse at that edge. Instead it expects the next pulse a full 33×L cycles after the kick edge. Any pulse at the earlier edge arrives at the monitor with the wrong timestamp and is reported.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int CTRL_W = 5;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_IEN   = 3'd1,
    RA_STAT  = 3'd2,
    RA_LOAD  = 3'd3,
    RA_KICK  = 3'd4,
    RA_COUNT = 3'd5
  } reg_addr_e;

  // bit 0 enable, bit 1 interrupt mode, bits 2..4 stall qualifiers
  typedef struct packed {
    logic stall_wk_en;
    logic stall_hib_en;
    logic stall_dbg_en;
    logic irq_mode;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/wdt_guard_prescale.sv
module wdt_guard_prescale #(
  parameter int DIV = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick_in,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign step = run && tick_in && (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             pcnt <= '0;
    else if (clear)         pcnt <= '0;
    else if (run && tick_in) pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
  end

  // R4: prescale phase never leaves its range
  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pcnt} < (PW+1)'(DIV));
  // R11: a held prescaler stays put
  a_r11_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(pcnt));
endmodule

// File: rtl/wdt_guard_regs.sv
module wdt_guard_regs
  import wdt_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] LOAD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt,
  input  logic          set_flag,
  output logic [DW-1:0] rdata,
  output ctrl_t         ctrl,
  output logic          ien,
  output logic          flag,
  output logic [DW-1:0] load_q,
  output logic          start,
  output logic          kick
);
  reg_addr_e ra;
  logic      w1c;

  assign ra    = reg_addr_e'(addr);
  assign start = wr_en && (ra == RA_CTRL) && wdata[0] && !ctrl.enable;
  assign kick  = wr_en && (ra == RA_KICK);
  assign w1c   = wr_en && (ra == RA_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      ien    <= 1'b0;
      flag   <= 1'b0;
      load_q <= LOAD_RST;
    end else begin
      if (wr_en && ra == RA_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_en && ra == RA_IEN)  ien  <= wdata[0];
      if (wr_en && ra == RA_LOAD) load_q <= (wdata == '0) ? DW'(1) : wdata;
      if (set_flag)               flag <= 1'b1;
      else if (w1c)               flag <= 1'b0;
    end
  end

  always_comb begin
    case (ra)
      RA_CTRL:  rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
      RA_IEN:   rdata = {{(DW-1){1'b0}}, ien};
      RA_STAT:  rdata = {{(DW-1){1'b0}}, flag};
      RA_LOAD:  rdata = load_q;
      RA_COUNT: rdata = cnt;
      default:  rdata = '0;
    endcase
  end

  // R10: the stored load value is never zero
  a_r10_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_q != '0);
  // R8: the flag only falls through a write of one
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !w1c) |=> flag);
endmodule

// File: rtl/wdt_guard_counter.sv
module wdt_guard_counter #(
  parameter int DW = 16,
  parameter logic [DW-1:0] LOAD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          kick,
  input  logic          step,
  input  logic          irq_mode,
  input  logic [DW-1:0] load_q,
  output logic [DW-1:0] cnt,
  output logic          set_flag,
  output logic          rst_req
);
  logic last_step;
  logic expire;

  assign last_step = (cnt <= DW'(1));
  assign expire    = step && !kick && !start && last_step;
  assign set_flag  = expire && irq_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= LOAD_RST;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire && !irq_mode;
      if (start || kick)   cnt <= load_q;
      else if (step)       cnt <= last_step ? load_q : cnt - 1'b1;
    end
  end

  // R5: reset request lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R6: interrupt mode never asks for reset
  a_r6_mode_blocks_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(irq_mode));
  // R9: a kick reloads the counter
  a_r9_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == $past(load_q)));
  // R3: no start, kick or step means the count is unchanged
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !kick && !step) |=> $stable(cnt));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter int PRESCALE = 33,
  parameter logic [DW-1:0] LOAD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32k,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          stall_dbg,
  input  logic          stall_hib,
  input  logic          stall_wk,
  output logic          irq,
  output logic          rst_req
);
  ctrl_t         ctrl;
  logic          ien, flag, start, kick, step, set_flag, stall_any, run;
  logic [DW-1:0] load_q, cnt;

  assign stall_any = (ctrl.stall_dbg_en && stall_dbg) ||
                     (ctrl.stall_hib_en && stall_hib) ||
                     (ctrl.stall_wk_en  && stall_wk);
  assign run = ctrl.enable && !stall_any;
  assign irq = flag && ien;

  wdt_guard_regs #(.DW(DW), .LOAD_RST(LOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .set_flag(set_flag), .rdata(rdata), .ctrl(ctrl), .ien(ien),
    .flag(flag), .load_q(load_q), .start(start), .kick(kick)
  );

  wdt_guard_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(start || kick), .run(run),
    .tick_in(tick_32k), .step(step)
  );

  wdt_guard_counter #(.DW(DW), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .kick(kick), .step(step),
    .irq_mode(ctrl.irq_mode), .load_q(load_q), .cnt(cnt),
    .set_flag(set_flag), .rst_req(rst_req)
  );

  // R11: a qualified stall freezes the count
  a_r11_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_any && !start && !kick) |=> $stable(cnt));
  // R3: a disabled watchdog never requests reset
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctrl.enable));
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  logic        clk = 0, rst_n = 0, tick = 1, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        s_dbg = 0, s_hib = 0, s_wk = 0, irq, rst_req;
  int total = 0, bad = 0;
  int cyc = 0;
  int exp_kind[$];
  int exp_cyc[$];
  int w;

  localparam int K_RST = 1, K_IRQ = 2, P = 33;

  wdt_guard uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .stall_dbg(s_dbg), .stall_hib(s_hib),
    .stall_wk(s_wk), .irq(irq), .rst_req(rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller sits at a negedge; the write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int at);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    at = cyc;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push(int k, int c);
    exp_kind.push_back(k); exp_cyc.push_back(c);
  endtask

  // monitor: pops expected events as the design produces them
  logic irq_q = 0, rst_q = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req && rst_q) check("R5 pulse width", 2, 1);
      if (rst_req || (irq && !irq_q)) begin
        if (exp_kind.size() == 0) check("R5/R6 unexpected event", rst_req ? K_RST : K_IRQ, 0);
        else begin
          check("R5/R7 event kind", rst_req ? K_RST : K_IRQ, exp_kind.pop_front());
          check("R9/R5 event cycle", cyc, exp_cyc.pop_front());
        end
      end
      irq_q <= irq; rst_q <= rst_req;
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 ien", v, 0);
    rd(2, v); check("R1 status", v, 0);
    rd(3, v); check("R1 load", v, 16'hFFFF);
    rd(5, v); check("R1 count", v, 16'hFFFF);
    check("R1 outputs", {irq, rst_req}, 0);
    rd(4, v); check("R2 kick reads zero", v, 0);

    // R10 load zero stored as one
    wr(3, 0, w); rd(3, v); check("R10 load zero", v, 1);

    // R5 reset mode expiry, R4 prescale
    wr(3, 3, w);
    wr(0, 1, w);
    push(K_RST, w + 3*P);
    rd(5, v); check("R3 start loads", v, 3);
    wait_to(w + P); rd(5, v); check("R4 first step", v, 2);
    wait_to(w + 3*P + 1); rd(5, v); check("R5 reload after expiry", v, 3);
    wr(0, 0, k);

    // R3 disable freezes count
    wr(3, 4, w); wr(0, 1, w);
    wait_to(w + 40); wr(0, 0, k);
    wait_to(w + 300); rd(5, v); check("R3 frozen count", v, 3);
    wr(0, 1, k); rd(5, v); check("R3 re-enable reload", v, 4);
    wr(0, 0, k);

    // R9 kick with arbitrary data
    wr(3, 3, w); wr(0, 1, w);
    wait_to(w + 50); wr(4, 16'hA5A5, k);
    rd(5, v); check("R9 kick reload", v, 3);
    push(K_RST, k + 3*P);
    wait_to(k + 3*P + 2); wr(0, 0, k);

    // R9 kick on the expiry edge wins
    wr(3, 2, w); wr(0, 1, w);
    wait_to(w + 2*P - 1); wr(4, 0, k);
    check("R9 kick at expiry edge", k, w + 2*P);
    push(K_RST, k + 2*P);
    wait_to(k + 2*P + 2); wr(0, 0, k);

    // R11 qualified stall delays, unqualified ignored
    wr(3, 2, w); wr(0, 5, w);
    push(K_RST, w + 2*P + 20);
    wait_to(w + 10); s_dbg = 1; s_hib = 1;
    repeat (20) @(negedge clk); s_dbg = 0;
    rd(5, v); check("R11 stall held count", v, 2);
    repeat (15) @(negedge clk); s_hib = 0; s_wk = 1;
    wait_to(w + 2*P + 22); s_wk = 0; wr(0, 0, k);

    // R6/R7/R8 interrupt mode
    wr(3, 2, w); wr(0, 3, w);
    wait_to(w + 2*P + 1);
    rd(2, v); check("R6 flag set", v, 1);
    check("R7 irq gated off", irq, 0);
    rd(5, v); check("R6 counter reloaded", v, 2);
    push(K_IRQ, w + 2*P + 2);
    wr(1, 1, k); check("R7 irq on", irq, 1);
    wr(2, 0, k); rd(2, v); check("R8 write zero ignored", v, 1);
    wr(2, 1, k); check("R8 w1c clears", irq, 0);
    push(K_IRQ, w + 4*P);
    wait_to(w + 4*P + 1); check("R6 second expiry", irq, 1);
    wr(0, 0, k); wr(2, 1, k);
    rd(2, v); check("R8 cleared", v, 0);

    repeat (5) @(negedge clk);
    check("R5 scoreboard drained", exp_kind.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule